// File: doc/BRIEF.md
# Balanced 4-to-6 Parity Codec with Soft Nearest-Codeword Decoding

This block turns each 4-bit nibble into a fixed 6-bit word that always holds three ones and three zeros. A stream of such words therefore carries no DC component. The same block also runs the reverse direction on the receive side. For each word it takes six signed soft samples, scores every one of the sixteen codewords by correlation, and returns the index of the best match.

Each word is handled on its own and no state carries from one word to the next. A corrupted word therefore affects only its own nibble. The encode side and the decode side each accept one item per cycle, marked by a valid strobe. Neither side applies back-pressure.

The decoder also raises a flag when the hard decisions on the six samples do not contain exactly three ones. In that case it still returns the nearest index.

Top module: `bal46_codec`

## Requirements
- R1: Nibble-to-word mapping, with the word written as bits 5 down to 0:
  - 0→010101, 1→000111, 2→010011, 3→010110
  - 4→001101, 5→001011, 6→001110, 7→011010
  - 8→100101, 9→110100, 10→100011, 11→110010
  - 12→101001, 13→101100, 14→111000, 15→101010
- R2: Every word the encoder emits contains exactly three ones.
- R3: The encoded word and its valid appear one clock edge after the input strobe. When no strobe arrives, the word output holds its last value and valid is low.
- R4: A decoded result and its valid appear two clock edges after the soft-input strobe.
- R5: Soft sample j sits in bits [8j+7:8j] of the soft input and is an 8-bit two's-complement value, where positive means a one. The decoder scores codeword k as the sum of +s_j over its one-bits and -s_j over its zero-bits. It returns the k with the highest score.
- R6: When several codewords share the highest score, the lowest index is returned.
- R7: The hard decision for sample j is 1 when s_j >= 0. The bad-word flag is 1 exactly when the six hard decisions do not contain three ones.
- R8: Decoding keeps no state between words. Strobes on consecutive cycles each yield their own result, and a cycle without a strobe yields no valid two edges later.
- R9: While reset is asserted, both valid outputs, the word output, the nibble output and the flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Nibble strobe |
| enc_nib_i | input | 4 | Nibble to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_word_o | output | 6 | Balanced word |
| dec_valid_i | input | 1 | Soft group strobe |
| dec_soft_i | input | 48 | Six signed samples, sample j in bits [8j+7:8j] |
| dec_valid_o | output | 1 | Decoded result valid |
| dec_nib_o | output | 4 | Index of the nearest codeword |
| dec_bad_o | output | 1 | Hard-decision weight is not three |

## Verification
The encode and decode paths may both take a strobe in the same cycle. Their results then come out on different edges because the two latencies differ. The bench issues such joint strobes in the same cycle as back-to-back decodes and keeps a separate expected queue for each path. Each queue entry records the cycle in which its result is due, so any cross-talk or latency slip shows up as a mismatch in value or arrival cycle.

// File: rtl/bal46_pkg.sv
package bal46_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned WORD_W = 6;
  localparam int unsigned NUM_CW = 1 << NIB_W;
  localparam int unsigned ONES_PER_WORD = WORD_W / 2;

  function automatic logic [WORD_W-1:0] cw_of(input logic [NIB_W-1:0] nib);
    logic [WORD_W-1:0] w;
    case (nib)
      4'h0: w = 6'b010101;
      4'h1: w = 6'b000111;
      4'h2: w = 6'b010011;
      4'h3: w = 6'b010110;
      4'h4: w = 6'b001101;
      4'h5: w = 6'b001011;
      4'h6: w = 6'b001110;
      4'h7: w = 6'b011010;
      4'h8: w = 6'b100101;
      4'h9: w = 6'b110100;
      4'hA: w = 6'b100011;
      4'hB: w = 6'b110010;
      4'hC: w = 6'b101001;
      4'hD: w = 6'b101100;
      4'hE: w = 6'b111000;
      default: w = 6'b101010;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/bal46_enc.sv
module bal46_enc
  import bal46_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic              valid_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) word_q <= cw_of(nib_i);
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;

  AST_ENC_BALANCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(word_o) == ONES_PER_WORD)); // R2
  AST_ENC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R3
  AST_ENC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(word_o))); // R3
endmodule

// File: rtl/bal46_corr.sv
module bal46_corr
  import bal46_pkg::*;
#(
  parameter int unsigned SAMP_W = 8,
  localparam int unsigned SCORE_W = SAMP_W + $clog2(WORD_W) + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [WORD_W*SAMP_W-1:0]    soft_i,
  output logic                        valid_o,
  output logic [NUM_CW*SCORE_W-1:0]   score_o,
  output logic [WORD_W-1:0]           hard_o
);
  logic signed [SCORE_W-1:0]   samp_ext [WORD_W];
  logic [NUM_CW*SCORE_W-1:0]   score_d, score_q;
  logic [WORD_W-1:0]           hard_d, hard_q;
  logic                        valid_q;

  for (genvar j = 0; j < WORD_W; j++) begin : g_samp
    assign samp_ext[j] = SCORE_W'($signed(soft_i[j*SAMP_W +: SAMP_W]));
    assign hard_d[j]   = ~soft_i[j*SAMP_W + SAMP_W - 1];
  end

  for (genvar k = 0; k < NUM_CW; k++) begin : g_cw
    localparam logic [WORD_W-1:0] CW = cw_of(NIB_W'(k));
    logic signed [SCORE_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < WORD_W; j++) begin
        if (CW[j]) acc = acc + samp_ext[j];
        else       acc = acc - samp_ext[j];
      end
    end
    assign score_d[k*SCORE_W +: SCORE_W] = acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      score_q <= '0;
      hard_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        score_q <= score_d;
        hard_q  <= hard_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign score_o = score_q;
  assign hard_o  = hard_q;

  AST_CORR_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R4
endmodule

// File: rtl/bal46_pick.sv
module bal46_pick
  import bal46_pkg::*;
#(
  parameter int unsigned SAMP_W = 8,
  localparam int unsigned SCORE_W = SAMP_W + $clog2(WORD_W) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [NUM_CW*SCORE_W-1:0] score_i,
  input  logic [WORD_W-1:0]         hard_i,
  output logic                      valid_o,
  output logic [NIB_W-1:0]          nib_o,
  output logic                      bad_o
);
  logic signed [SCORE_W-1:0] best;
  logic [NIB_W-1:0]          best_idx;
  logic                      bad_d;
  logic                      valid_q, bad_q;
  logic [NIB_W-1:0]          nib_q;

  // strict compare keeps the lower index on ties
  always_comb begin
    best     = $signed(score_i[0 +: SCORE_W]);
    best_idx = '0;
    for (int k = 1; k < NUM_CW; k++) begin
      if ($signed(score_i[k*SCORE_W +: SCORE_W]) > best) begin
        best     = $signed(score_i[k*SCORE_W +: SCORE_W]);
        best_idx = NIB_W'(k);
      end
    end
  end

  assign bad_d = ($countones(hard_i) != ONES_PER_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      nib_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        nib_q <= best_idx;
        bad_q <= bad_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign nib_o   = nib_q;
  assign bad_o   = bad_q;

  AST_PICK_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R4
  AST_PICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(nib_o))); // R8
endmodule

// File: rtl/bal46_codec.sv
module bal46_codec
  import bal46_pkg::*;
#(
  parameter int unsigned SAMP_W = 8,
  localparam int unsigned SCORE_W = SAMP_W + $clog2(WORD_W) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enc_valid_i,
  input  logic [NIB_W-1:0]         enc_nib_i,
  output logic                     enc_valid_o,
  output logic [WORD_W-1:0]        enc_word_o,
  input  logic                     dec_valid_i,
  input  logic [WORD_W*SAMP_W-1:0] dec_soft_i,
  output logic                     dec_valid_o,
  output logic [NIB_W-1:0]         dec_nib_o,
  output logic                     dec_bad_o
);
  logic                      s1_valid;
  logic [NUM_CW*SCORE_W-1:0] s1_score;
  logic [WORD_W-1:0]         s1_hard;

  bal46_enc u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (enc_valid_i),
    .nib_i   (enc_nib_i),
    .valid_o (enc_valid_o),
    .word_o  (enc_word_o)
  );

  bal46_corr #(.SAMP_W(SAMP_W)) u_corr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (dec_valid_i),
    .soft_i  (dec_soft_i),
    .valid_o (s1_valid),
    .score_o (s1_score),
    .hard_o  (s1_hard)
  );

  bal46_pick #(.SAMP_W(SAMP_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .score_i (s1_score),
    .hard_i  (s1_hard),
    .valid_o (dec_valid_o),
    .nib_o   (dec_nib_o),
    .bad_o   (dec_bad_o)
  );

  AST_DEC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> ##1 dec_valid_o); // R4
  AST_DEC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> ##1 !dec_valid_o); // R8
endmodule

// File: tb/bal46_codec_bench.sv
`timescale 1ns/1ps
module bal46_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_valid_i = 1'b0;
  logic [3:0]  enc_nib_i = '0;
  logic        enc_valid_o;
  logic [5:0]  enc_word_o;
  logic        dec_valid_i = 1'b0;
  logic [47:0] dec_soft_i = '0;
  logic        dec_valid_o;
  logic [3:0]  dec_nib_o;
  logic        dec_bad_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct { logic [5:0] w; int due; } enc_item_t;
  typedef struct { logic [3:0] n; logic b; int due; } dec_item_t;
  enc_item_t enc_q[$];
  dec_item_t dec_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bal46_codec u_bal46_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_valid_i(enc_valid_i), .enc_nib_i(enc_nib_i),
    .enc_valid_o(enc_valid_o), .enc_word_o(enc_word_o),
    .dec_valid_i(dec_valid_i), .dec_soft_i(dec_soft_i),
    .dec_valid_o(dec_valid_o), .dec_nib_o(dec_nib_o), .dec_bad_o(dec_bad_o)
  );

  function automatic logic [5:0] ref_cw(input int k);
    logic [5:0] t [16] = '{6'b010101, 6'b000111, 6'b010011, 6'b010110,
                           6'b001101, 6'b001011, 6'b001110, 6'b011010,
                           6'b100101, 6'b110100, 6'b100011, 6'b110010,
                           6'b101001, 6'b101100, 6'b111000, 6'b101010};
    return t[k];
  endfunction

  function automatic int samp(input logic [47:0] s, input int j);
    return int'($signed(s[j*8 +: 8]));
  endfunction

  function automatic logic [47:0] soft_of(input logic [5:0] w, input int amp);
    logic [47:0] s;
    for (int j = 0; j < 6; j++) s[j*8 +: 8] = w[j] ? 8'(amp) : 8'(-amp);
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
  endtask

  // R1 R2 R3: expected word due one edge later
  task automatic put_enc(input logic [3:0] n);
    enc_item_t it;
    enc_valid_i = 1'b1;
    enc_nib_i   = n;
    it.w = ref_cw(int'(n));
    it.due = cyc + 1;
    enc_q.push_back(it);
  endtask

  // R5 R6 R7: correlation argmax with lowest index on ties, weight flag
  task automatic put_dec(input logic [47:0] s);
    dec_item_t it;
    int best, sc, ones;
    best = -100000;
    it.n = 0;
    for (int k = 0; k < 16; k++) begin
      sc = 0;
      for (int j = 0; j < 6; j++) sc += ref_cw(k)[j] ? samp(s, j) : -samp(s, j);
      if (sc > best) begin best = sc; it.n = 4'(k); end
    end
    ones = 0;
    for (int j = 0; j < 6; j++) if (samp(s, j) >= 0) ones++;
    it.b = (ones != 3);
    it.due = cyc + 2;
    dec_valid_i = 1'b1;
    dec_soft_i  = s;
    dec_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && enc_valid_o) begin
      if (enc_q.size() == 0) chk("R3 unexpected enc valid", 1, 0);
      else begin
        enc_item_t e;
        e = enc_q.pop_front();
        chk("R1 enc word", int'(enc_word_o), int'(e.w));
        chk("R2 enc ones", $countones(enc_word_o), 3);
        chk("R3 enc cycle", cyc, e.due);
      end
    end
    if (rst_n && dec_valid_o) begin
      if (dec_q.size() == 0) chk("R8 unexpected dec valid", 1, 0);
      else begin
        dec_item_t d;
        d = dec_q.pop_front();
        chk("R5 dec nibble", int'(dec_nib_o), int'(d.n));
        chk("R7 dec flag", int'(dec_bad_o), int'(d.b));
        chk("R4 dec cycle", cyc, d.due);
      end
    end
  end

  initial begin
    #(5ns * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] s;
    repeat (3) @(negedge clk);
    chk("R9 reset enc valid", int'(enc_valid_o), 0);
    chk("R9 reset enc word", int'(enc_word_o), 0);
    chk("R9 reset dec valid", int'(dec_valid_o), 0);
    chk("R9 reset dec nib", int'(dec_nib_o), 0);
    chk("R9 reset dec flag", int'(dec_bad_o), 0);
    rst_n = 1'b1;
    tick();

    // R1: every nibble, back to back
    for (int k = 0; k < 16; k++) begin put_enc(4'(k)); tick(); end
    repeat (3) tick();
    chk("R3 hold word", int'(enc_word_o), int'(6'b101010));
    chk("R3 idle valid", int'(enc_valid_o), 0);

    // R5: clean codewords, full and small amplitude
    for (int k = 0; k < 16; k++) begin put_dec(soft_of(ref_cw(k), 64)); tick(); end
    for (int k = 0; k < 16; k++) begin put_dec(soft_of(ref_cw(k), 1)); tick(); end
    tick();
    // R5 R7: weak wrong-sign sample on a one-bit
    s = soft_of(ref_cw(9), 60);
    s[2*8 +: 8] = 8'(-10);
    put_dec(s); tick();
    // R6 R7: all-zero samples tie every codeword
    put_dec('0); tick();
    // R6: codewords 1 and 2 tie
    s = soft_of(6'b000011, 64);
    s[2*8 +: 8] = 8'd0;
    s[4*8 +: 8] = 8'd0;
    put_dec(s); tick();
    // R5: extreme values
    s = soft_of(ref_cw(14), 127);
    put_dec(s); tick();
    s = {8'h80, 8'h80, 8'h80, 8'h7f, 8'h7f, 8'h7f};
    put_dec(s); tick();
    repeat (3) tick();

    // R8: joint encode/decode strobes with random soft groups, gaps mixed in
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) != 0) put_enc(4'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) != 0) begin
        for (int j = 0; j < 6; j++) s[j*8 +: 8] = 8'($urandom_range(0, 255));
        put_dec(s);
      end
      tick();
    end
    repeat (4) tick();
    chk("R8 enc queue drained", enc_q.size(), 0);
    chk("R8 dec queue drained", dec_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule